// File: doc/BRIEF.md
# RTC Interrupt Flag Controller

This block holds the interrupt side of a real-time-clock register file. Three single-cycle event pulses come in: a periodic tick, an alarm match and an update-ended mark. Each pulse sets its own pending flag. An eight-bit control register holds one enable bit per source and a square-wave enable bit. When any pending flag has its enable set, the block asserts a drive-enable for an active-low, open-drain interrupt line. The line is only ever pulled low or released, so several devices can share one pulled-up wire.

Software reads a status word that reports the three flags and a summary bit. The read clears the flags, which releases the interrupt line.

An external active-low reset pin clears the enables, the flags and the square-wave enable, but only while the supply is good. It leaves the remaining control bits, time data and memory alone. Register access is blocked while that pin is low and while the supply is below its fail threshold. A three-state access machine tracks these conditions:

- `ST_ACTIVE`: access is allowed.
- `ST_RESET_HOLD`: the pin is low and the supply is good.
- `ST_SUPPLY_LOW`: the supply is below its fail threshold.

The machine makes these transitions:

- `ACTIVE→RESET_HOLD`: the pin is low and the supply is good.
- `ACTIVE→SUPPLY_LOW` and `RESET_HOLD→SUPPLY_LOW`: the supply fails.
- `RESET_HOLD→ACTIVE`: the pin returns high.
- `SUPPLY_LOW→ACTIVE`: the supply is good and the pin is high.
- `SUPPLY_LOW→RESET_HOLD`: the supply is good and the pin is low.

Top module: `rtcirq_irq_ctrl`

## Requirements
- R1: After the system reset `rst_n` is released, the control register reads 0x00 and the status word reads 0x00. `irq_drive` is 0 and `bus_ok` is 1.
- R2: An event pulse sets its flag even when the matching enable is 0. `irq_drive` then stays 0. In the status word, bit 6 is the periodic flag, bit 5 the alarm flag and bit 4 the update-ended flag. Bits 3..0 read 0.
- R3: Status bit 7 and `irq_drive` both equal (periodic flag AND control bit 6) OR (alarm flag AND control bit 5) OR (update flag AND control bit 4). `irq_drive` is 0 in `ST_RESET_HOLD`.
- R4: An accepted status read returns the current word in the same cycle. It clears all three flags at the next edge.
- R5: An event pulse in the same cycle as a status read leaves its flag set after that edge.
- R6: A clock edge that samples `reset_pin_n` low while `supply_low` is 0 clears control bits 6..3 and all flags. Control bits 7 and 2..0 keep their values.
- R7: `bus_ok` is 0 from the edge that samples the pin low (supply good) up to the edge that samples it high again. While `bus_ok` is 0, writes change nothing, reads return 0x00 and a status read clears no flag.
- R8: An edge that samples `supply_low` high makes `bus_ok` 0. While the supply is low, a low reset pin clears nothing and the flags still latch events.
- R9: `bus_ok` returns to 1 one edge after the supply is good and the pin is high.
- R10: A control read returns the last accepted write. A status read takes priority over a control read in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low system reset, clears all state |
| reset_pin_n | input | 1 | Active-low external reset pin |
| supply_low | input | 1 | Supply is below the power-fail threshold |
| evt_periodic | input | 1 | Periodic tick pulse |
| evt_alarm | input | 1 | Alarm match pulse |
| evt_update | input | 1 | Update-ended pulse |
| ctrl_wr | input | 1 | Write strobe for the control register |
| wr_data | input | 8 | Control register write data |
| ctrl_rd | input | 1 | Read strobe for the control register |
| status_rd | input | 1 | Read strobe for the status word (clears flags) |
| rd_data | output | 8 | Read data, valid in the strobe cycle |
| irq_drive | output | 1 | 1 pulls the open-drain interrupt line low |
| bus_ok | output | 1 | Register access is currently permitted |

## Verification
The bench aims at three collisions:

- An event landing in the same cycle as a status read. A design that applies the clear after the set loses that interrupt for good.
- A write or read arriving while the reset pin is low or the supply has failed. A leaky design lets the write through, or lets the blocked read still clear flags.
- The pin dropping while the supply is low. A design that clears regardless of supply wipes enables it should keep.

Flags latched with their enables at 0 are checked too. A design gating the latch instead of the interrupt would report no pending flag, and would not raise the interrupt when the enable is later set.

// File: rtl/rtcirq_pkg.sv
`timescale 1ns/1ps
package rtcirq_pkg;

    localparam int REG_W       = 8;
    localparam int NUM_SRC     = 3;
    localparam int SRC_UPDATE  = 0;
    localparam int SRC_ALARM   = 1;
    localparam int SRC_PERIOD  = 2;
    localparam int EN_LSB      = 4;
    localparam int FLAG_LSB    = 4;
    localparam int SQWE_BIT    = 3;
    localparam int SUMMARY_BIT = 7;

    // Control bits that survive a reset-pin clear
    localparam logic [REG_W-1:0] PIN_KEEP_MASK = 8'h87;

    typedef enum logic [1:0] {
        ST_ACTIVE     = 2'd0,
        ST_RESET_HOLD = 2'd1,
        ST_SUPPLY_LOW = 2'd2
    } access_state_t;

endpackage

// File: rtl/rtcirq_access_fsm.sv
`timescale 1ns/1ps
module rtcirq_access_fsm
    import rtcirq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic reset_pin_n,
    input  logic supply_low,
    output logic bus_ok,
    output logic irq_permit,
    output logic hold_clear
);

    access_state_t state_q;
    access_state_t state_d;

    // Clearing follows the pin only while the supply is good
    assign hold_clear = !reset_pin_n && !supply_low;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_ACTIVE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_ACTIVE: begin
                if (supply_low)        state_d = ST_SUPPLY_LOW;
                else if (!reset_pin_n) state_d = ST_RESET_HOLD;
            end
            ST_RESET_HOLD: begin
                if (supply_low)        state_d = ST_SUPPLY_LOW;
                else if (reset_pin_n)  state_d = ST_ACTIVE;
            end
            ST_SUPPLY_LOW: begin
                if (!supply_low) begin
                    if (reset_pin_n)   state_d = ST_ACTIVE;
                    else               state_d = ST_RESET_HOLD;
                end
            end
            default:                   state_d = ST_ACTIVE;
        endcase
    end

    always_comb begin
        bus_ok     = 1'b0;
        irq_permit = 1'b1;
        unique case (state_q)
            ST_ACTIVE:     bus_ok     = 1'b1;
            ST_RESET_HOLD: irq_permit = 1'b0;
            ST_SUPPLY_LOW: bus_ok     = 1'b0;
            default:       bus_ok     = 1'b0;
        endcase
    end

endmodule

// File: rtl/rtcirq_enable_reg.sv
`timescale 1ns/1ps
module rtcirq_enable_reg #(
    parameter int               WIDTH     = 8,
    parameter logic [WIDTH-1:0] KEEP_MASK = 8'h87
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hold_clear,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    output logic [WIDTH-1:0] ctrl_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (hold_clear) begin
            ctrl_q <= ctrl_q & KEEP_MASK;
        end else if (wr_en) begin
            ctrl_q <= wr_data;
        end
    end

endmodule

// File: rtl/rtcirq_flag_unit.sv
`timescale 1ns/1ps
module rtcirq_flag_unit #(
    parameter int NSRC = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            hold_clear,
    input  logic            read_clear,
    input  logic [NSRC-1:0] events,
    input  logic [NSRC-1:0] enables,
    output logic [NSRC-1:0] flags_q,
    output logic            summary
);

    logic [NSRC-1:0] pending;

    for (genvar g = 0; g < NSRC; g++) begin : g_src
        // A read clears first; a same-cycle event then sets again
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                flags_q[g] <= 1'b0;
            end else if (hold_clear) begin
                flags_q[g] <= 1'b0;
            end else begin
                flags_q[g] <= (flags_q[g] & !read_clear) | events[g];
            end
        end
        assign pending[g] = flags_q[g] & enables[g];
    end

    assign summary = |pending;

endmodule

// File: rtl/rtcirq_irq_ctrl.sv
`timescale 1ns/1ps
module rtcirq_irq_ctrl
    import rtcirq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reset_pin_n,
    input  logic             supply_low,
    input  logic             evt_periodic,
    input  logic             evt_alarm,
    input  logic             evt_update,
    input  logic             ctrl_wr,
    input  logic [REG_W-1:0] wr_data,
    input  logic             ctrl_rd,
    input  logic             status_rd,
    output logic [REG_W-1:0] rd_data,
    output logic             irq_drive,
    output logic             bus_ok
);

    logic               hold_clear;
    logic               irq_permit;
    logic [REG_W-1:0]   ctrl_q;
    logic [NUM_SRC-1:0] flags_q;
    logic [NUM_SRC-1:0] events;
    logic               summary;
    logic [REG_W-1:0]   status_word;

    assign events[SRC_PERIOD] = evt_periodic;
    assign events[SRC_ALARM]  = evt_alarm;
    assign events[SRC_UPDATE] = evt_update;

    rtcirq_access_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .reset_pin_n (reset_pin_n),
        .supply_low  (supply_low),
        .bus_ok      (bus_ok),
        .irq_permit  (irq_permit),
        .hold_clear  (hold_clear)
    );

    rtcirq_enable_reg #(
        .WIDTH     (REG_W),
        .KEEP_MASK (PIN_KEEP_MASK)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .hold_clear (hold_clear),
        .wr_en      (ctrl_wr && bus_ok),
        .wr_data    (wr_data),
        .ctrl_q     (ctrl_q)
    );

    rtcirq_flag_unit #(
        .NSRC (NUM_SRC)
    ) u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .hold_clear (hold_clear),
        .read_clear (status_rd && bus_ok),
        .events     (events),
        .enables    (ctrl_q[EN_LSB +: NUM_SRC]),
        .flags_q    (flags_q),
        .summary    (summary)
    );

    always_comb begin
        status_word                          = '0;
        status_word[SUMMARY_BIT]             = summary;
        status_word[FLAG_LSB +: NUM_SRC]     = flags_q;
    end

    always_comb begin
        rd_data = '0;
        if (bus_ok) begin
            if (status_rd)    rd_data = status_word;
            else if (ctrl_rd) rd_data = ctrl_q;
        end
    end

    assign irq_drive = summary && irq_permit;

endmodule

// File: rtl/rtcirq_irq_ctrl_checks.sv
`timescale 1ns/1ps
module rtcirq_irq_ctrl_checks
    import rtcirq_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               reset_pin_n,
    input logic               supply_low,
    input logic               evt_periodic,
    input logic               evt_alarm,
    input logic               evt_update,
    input logic               ctrl_wr,
    input logic               status_rd,
    input logic               bus_ok,
    input logic               irq_drive,
    input logic [REG_W-1:0]   ctrl_q,
    input logic [NUM_SRC-1:0] flags_q
);

    assert_irq_needs_enable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        irq_drive |-> (|(flags_q & ctrl_q[EN_LSB +: NUM_SRC])));

    assert_read_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_ok && status_rd && !evt_periodic && !evt_alarm && !evt_update) |=> (flags_q == '0));

    assert_event_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_periodic && (reset_pin_n || supply_low)) |=> flags_q[SRC_PERIOD]);

    assert_pin_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!reset_pin_n && !supply_low) |=> (ctrl_q[6:3] == 4'd0 && flags_q == '0 && !irq_drive));

    assert_blocked_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_ok && ctrl_wr && (reset_pin_n || supply_low)) |=> $stable(ctrl_q));

    assert_supply_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
        supply_low |=> !bus_ok);

    assert_resume_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (reset_pin_n && !supply_low) |=> bus_ok);

endmodule

bind rtcirq_irq_ctrl rtcirq_irq_ctrl_checks u_checks (
    .clk          (clk),
    .rst_n        (rst_n),
    .reset_pin_n  (reset_pin_n),
    .supply_low   (supply_low),
    .evt_periodic (evt_periodic),
    .evt_alarm    (evt_alarm),
    .evt_update   (evt_update),
    .ctrl_wr      (ctrl_wr),
    .status_rd    (status_rd),
    .bus_ok       (bus_ok),
    .irq_drive    (irq_drive),
    .ctrl_q       (ctrl_q),
    .flags_q      (flags_q)
);

// File: tb/rtcirq_irq_ctrl_test.sv
`timescale 1ns/1ps
module rtcirq_irq_ctrl_test;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       reset_pin_n;
    logic       supply_low;
    logic       evt_periodic, evt_alarm, evt_update;
    logic       ctrl_wr, ctrl_rd, status_rd;
    logic [7:0] wr_data;
    logic [7:0] rd_data;
    logic       irq_drive;
    logic       bus_ok;

    int  n_vec  = 0;
    int  n_bad  = 0;
    bit  done   = 1'b0;

    // bench model: ctrl, flags {periodic, alarm, update}, state 0 active / 1 hold / 2 supply low
    logic [7:0] m_ctrl;
    logic [2:0] m_flags;
    int         m_st;

    always #4 clk = ~clk;

    rtcirq_irq_ctrl uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .reset_pin_n  (reset_pin_n),
        .supply_low   (supply_low),
        .evt_periodic (evt_periodic),
        .evt_alarm    (evt_alarm),
        .evt_update   (evt_update),
        .ctrl_wr      (ctrl_wr),
        .wr_data      (wr_data),
        .ctrl_rd      (ctrl_rd),
        .status_rd    (status_rd),
        .rd_data      (rd_data),
        .irq_drive    (irq_drive),
        .bus_ok       (bus_ok)
    );

    function automatic logic m_summary();
        return |(m_flags & m_ctrl[6:4]);
    endfunction

    function automatic logic [7:0] m_read(bit cr, bit sr);
        if (m_st != 0) return 8'h00;
        if (sr)        return {m_summary(), m_flags, 4'b0000};
        if (cr)        return m_ctrl;
        return 8'h00;
    endfunction

    task automatic check(string tag, string what, logic [7:0] act, logic [7:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic cycle(string tag, bit pin, bit sl, bit [2:0] ev,
                         bit cw, bit [7:0] wd, bit cr, bit sr);
        bit hold;
        @(negedge clk);
        reset_pin_n  = pin;
        supply_low   = sl;
        evt_periodic = ev[2];
        evt_alarm    = ev[1];
        evt_update   = ev[0];
        ctrl_wr      = cw;
        wr_data      = wd;
        ctrl_rd      = cr;
        status_rd    = sr;
        #2;
        check(tag, "rd_data",   rd_data,          m_read(cr, sr));
        check(tag, "irq_drive", {7'd0, irq_drive}, {7'd0, m_summary() && (m_st != 1)});
        check(tag, "bus_ok",    {7'd0, bus_ok},    {7'd0, m_st == 0});
        @(posedge clk);
        hold = !pin && !sl;
        if (hold) begin
            m_ctrl  = m_ctrl & 8'h87;
            m_flags = 3'b000;
        end else begin
            if (m_st == 0 && cw) m_ctrl = wd;
            m_flags = ((m_st == 0 && sr) ? 3'b000 : m_flags) | ev;
        end
        m_st = sl ? 2 : (!pin ? 1 : 0);
    endtask

    task automatic idle(string tag);
        cycle(tag, 1, 0, 3'b000, 0, 8'h00, 0, 0);
    endtask

    task automatic wr(string tag, bit [7:0] v);
        cycle(tag, 1, 0, 3'b000, 1, v, 0, 0);
    endtask

    task automatic rd_ctrl(string tag);
        cycle(tag, 1, 0, 3'b000, 0, 8'h00, 1, 0);
    endtask

    task automatic rd_stat(string tag);
        cycle(tag, 1, 0, 3'b000, 0, 8'h00, 0, 1);
    endtask

    initial begin
        #1600000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0;
        reset_pin_n = 1'b1; supply_low = 1'b0;
        evt_periodic = 1'b0; evt_alarm = 1'b0; evt_update = 1'b0;
        ctrl_wr = 1'b0; ctrl_rd = 1'b0; status_rd = 1'b0; wr_data = 8'h00;
        m_ctrl = 8'h00; m_flags = 3'b000; m_st = 0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1 reset state
        rd_stat("R1");
        rd_ctrl("R1");

        // R10 control write and readback, status priority
        wr("R10", 8'h75);
        rd_ctrl("R10");
        cycle("R10", 1, 0, 3'b000, 0, 8'h00, 1, 1);
        wr("R10", 8'h00);

        // R2 flag latches with enable off
        cycle("R2", 1, 0, 3'b010, 0, 8'h00, 0, 0);
        idle("R2");
        rd_stat("R2");
        // R4 flags gone after read
        rd_stat("R4");

        // R3 enable periodic; alarm alone does not interrupt
        wr("R3", 8'h40);
        cycle("R3", 1, 0, 3'b010, 0, 8'h00, 0, 0);
        idle("R3");
        cycle("R3", 1, 0, 3'b100, 0, 8'h00, 0, 0);
        idle("R3");
        rd_stat("R3");
        idle("R4");

        // R5 event coinciding with a status read
        cycle("R5", 1, 0, 3'b100, 0, 8'h00, 0, 0);
        cycle("R5", 1, 0, 3'b100, 0, 8'h00, 0, 1);
        idle("R5");
        rd_stat("R5");

        // R6 / R7 pin reset with supply good
        wr("R6", 8'hFF);
        cycle("R6", 1, 0, 3'b111, 0, 8'h00, 0, 0);
        idle("R6");
        cycle("R6", 0, 0, 3'b000, 0, 8'h00, 0, 0);
        cycle("R7", 0, 0, 3'b101, 1, 8'h7F, 0, 0);
        cycle("R7", 0, 0, 3'b000, 0, 8'h00, 1, 0);
        cycle("R7", 0, 0, 3'b000, 0, 8'h00, 0, 1);
        idle("R9");
        idle("R9");
        rd_ctrl("R6");
        rd_stat("R6");

        // R8 supply low: pin reset has no effect, flags still latch
        wr("R8", 8'h70);
        cycle("R8", 1, 0, 3'b001, 0, 8'h00, 0, 0);
        cycle("R8", 0, 1, 3'b100, 1, 8'h00, 0, 0);
        cycle("R8", 0, 1, 3'b000, 0, 8'h00, 0, 1);
        cycle("R8", 0, 1, 3'b000, 1, 8'h00, 1, 0);
        idle("R9");
        idle("R9");
        rd_ctrl("R8");
        rd_stat("R8");
        idle("R8");

        // mixed random traffic, all rules checked by the model
        for (int i = 0; i < 4000; i++) begin
            bit       pin, sl, cw, cr, sr;
            bit [2:0] ev;
            pin   = ($urandom % 20) != 0;
            sl    = ($urandom % 25) == 0;
            ev[2] = ($urandom % 6) == 0;
            ev[1] = ($urandom % 6) == 0;
            ev[0] = ($urandom % 6) == 0;
            cw    = ($urandom % 8) == 0;
            cr    = ($urandom % 6) == 0;
            sr    = ($urandom % 5) == 0;
            cycle("R3", pin, sl, ev, cw, 8'($urandom), cr, sr);
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule